// File: doc/BRIEF.md
# Software Trap Entry and Return Sequencer

This block is the control sequencer that a 16-bit, word-addressed processor uses to take a software trap and to return from one. It owns the program counter, the flags word, the two stack pointers and the trap-table base. Each of the two sequences is a short series of single-word memory transactions on a request/ready port. The processor's decoder starts a sequence with a one-cycle `swi_go` or `rti_go` strobe. It waits while `busy` is high and resumes when `done` pulses.

Both stacks grow downward, and each pointer points at the most recently stored word. Trap entry stores the return PC on the stack of the mode that is currently running. It then stores the flags word on the supervisor stack in every case. After that it switches to supervisor mode, marks a trap as in progress, and loads the new PC from a table indexed by the low byte of R0. Trap return first clears the in-progress mark and restores the flags word from the supervisor stack. The supervisor bit of that restored word then selects the stack from which the PC is recovered, so a trap taken from user code returns to user mode on its own stack.

Flags word layout: bit 15 is the supervisor bit (1 = supervisor mode, 0 = user mode), bit 14 is the trap-in-progress bit, and bits 13..0 are carried through unchanged by entry.

Top module: `trap_sequencer`

## Requirements
- R1: Stacks are full-descending. A push writes at SP-1 and leaves SP one lower. A pop reads at SP and leaves SP one higher.
- R2: On trap entry the current PC is the first word written. It goes to the user stack when FL bit 15 is 0 and to the supervisor stack when FL bit 15 is 1.
- R3: On trap entry the flags word is the second word written, always onto the supervisor stack, with its value from before entry.
- R4: When entry completes, FL bits 15 and 14 are both 1 and FL bits 13..0 equal their value before entry.
- R5: When entry completes, PC equals the memory word at VEC_BASE + R0[7:0]. R0 bits 15..8 have no effect on the result.
- R6: On trap return, FL bit 14 reads 0 from the cycle after the strobe is accepted until the flags word is popped. FL then takes the popped word exactly.
- R7: On trap return, PC is popped from the supervisor stack if the restored FL bit 15 is 1, and from the user stack otherwise. The other stack pointer is unchanged.
- R8: After reset, PC=0x0040, FL=0x0005 (user mode), SSP=0x0200, USP=0x0100, and busy and done are 0.
- R9: busy is 1 from the cycle after a strobe is accepted up to and including the single cycle in which done is 1. Strobes that arrive while busy is 1 have no effect.
- R10: If swi_go and rti_go are both 1 in an idle cycle, trap entry is performed and the return strobe is dropped.
- R11: While a memory request waits for ready, the request, its address and its write enable stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| swi_go | input | 1 | One-cycle strobe that starts trap entry |
| rti_go | input | 1 | One-cycle strobe that starts trap return |
| r0_val | input | 16 | Current R0; its low byte selects the table slot |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while mem_rdy is 1 |
| mem_rdy | input | 1 | Transaction completes in a cycle with mem_req and mem_rdy both 1 |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence has finished |
| pc_out | output | 16 | Program counter |
| fl_out | output | 16 | Flags word |
| ssp_out | output | 16 | Supervisor stack pointer |
| usp_out | output | 16 | User stack pointer |

## Verification
The assertions take for granted that mem_rdata is valid in any cycle in which a read request meets mem_rdy. They also take for granted that strobes come only from a decoder that holds each one for a single cycle, and that reset is applied from time zero. The bench's memory model returns the word at the requested address in the same cycle and moves ready with a free-running shift register, so stalls of several lengths fall inside every state. Strobes are driven on falling edges for exactly one cycle. The only overlapping strobes are the deliberate ones aimed at the ignore and priority rules.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned SUP_BIT = 15;
  localparam int unsigned IIP_BIT = 14;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_PC = 3'd1,
    ST_PUSH_FL = 3'd2,
    ST_VEC     = 3'd3,
    ST_POP_FL  = 3'd4,
    ST_POP_PC  = 3'd5,
    ST_FIN     = 3'd6
  } seq_state_e;

  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_DEC  = 2'd1,
    SP_INC  = 2'd2
  } sp_op_e;

  typedef struct packed {
    logic   pc_ld;
    word_t  pc_val;
    logic   fl_ld;
    word_t  fl_val;
    sp_op_e ssp_op;
    sp_op_e usp_op;
  } ctx_cmd_t;

  // slot a push writes into (full-descending)
  function automatic word_t push_slot(word_t sp);
    return sp - word_t'(1);
  endfunction

  // pointer value after a pop
  function automatic word_t pop_next(word_t sp);
    return sp + word_t'(1);
  endfunction

  function automatic word_t vector_slot(word_t base, word_t sel, int unsigned idx_w);
    word_t mask;
    mask = word_t'((32'd1 << idx_w) - 32'd1);
    return base + (sel & mask);
  endfunction

  function automatic word_t enter_flags(word_t fl);
    word_t r;
    r = fl;
    r[SUP_BIT] = 1'b1;
    r[IIP_BIT] = 1'b1;
    return r;
  endfunction

  function automatic word_t clear_iip(word_t fl);
    word_t r;
    r = fl;
    r[IIP_BIT] = 1'b0;
    return r;
  endfunction

  function automatic word_t apply_sp(word_t sp, sp_op_e op);
    case (op)
      SP_DEC:  return push_slot(sp);
      SP_INC:  return pop_next(sp);
      default: return sp;
    endcase
  endfunction
endpackage

// File: rtl/trap_ctx.sv
module trap_ctx
  import trap_pkg::*;
#(
  parameter word_t PC_RST  = 16'h0040,
  parameter word_t FL_RST  = 16'h0005,
  parameter word_t SSP_RST = 16'h0200,
  parameter word_t USP_RST = 16'h0100
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ctx_cmd_t cmd,
  output word_t    pc_q,
  output word_t    fl_q,
  output word_t    ssp_q,
  output word_t    usp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= PC_RST;
      fl_q  <= FL_RST;
      ssp_q <= SSP_RST;
      usp_q <= USP_RST;
    end else begin
      if (cmd.pc_ld) pc_q <= cmd.pc_val;
      if (cmd.fl_ld) fl_q <= cmd.fl_val;
      ssp_q <= apply_sp(ssp_q, cmd.ssp_op);
      usp_q <= apply_sp(usp_q, cmd.usp_op);
    end
  end
endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
  import trap_pkg::*;
#(
  parameter word_t       VEC_BASE = 16'h0300,
  parameter int unsigned IDX_W    = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     swi_go,
  input  logic     rti_go,
  input  word_t    r0_val,
  input  word_t    pc_q,
  input  word_t    fl_q,
  input  word_t    ssp_q,
  input  word_t    usp_q,
  input  word_t    mem_rdata,
  input  logic     mem_rdy,
  output logic     mem_req,
  output logic     mem_we,
  output word_t    mem_addr,
  output word_t    mem_wdata,
  output ctx_cmd_t cmd,
  output logic     busy,
  output logic     done,
  output logic     ev_pc_push,
  output logic     ev_fl_push,
  output logic     ev_vec_rd,
  output logic     ev_fl_pop,
  output logic     ev_pc_pop
);
  seq_state_e state_q, state_d;
  word_t      idx_q;
  logic       sup;

  assign sup = fl_q[SUP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && swi_go) idx_q <= r0_val;
    end
  end

  always_comb begin
    state_d   = state_q;
    cmd       = '0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_IDLE: begin
        if (swi_go) begin
          state_d = ST_PUSH_PC;
        end else if (rti_go) begin
          cmd.fl_ld  = 1'b1;
          cmd.fl_val = clear_iip(fl_q);
          state_d    = ST_POP_FL;
        end
      end
      ST_PUSH_PC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = push_slot(sup ? ssp_q : usp_q);
        mem_wdata = pc_q;
        if (mem_rdy) begin
          if (sup) cmd.ssp_op = SP_DEC;
          else     cmd.usp_op = SP_DEC;
          state_d = ST_PUSH_FL;
        end
      end
      ST_PUSH_FL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = push_slot(ssp_q);
        mem_wdata = fl_q;
        if (mem_rdy) begin
          cmd.ssp_op = SP_DEC;
          cmd.fl_ld  = 1'b1;
          cmd.fl_val = enter_flags(fl_q);
          state_d    = ST_VEC;
        end
      end
      ST_VEC: begin
        mem_req  = 1'b1;
        mem_addr = vector_slot(VEC_BASE, idx_q, IDX_W);
        if (mem_rdy) begin
          cmd.pc_ld  = 1'b1;
          cmd.pc_val = mem_rdata;
          state_d    = ST_FIN;
        end
      end
      ST_POP_FL: begin
        mem_req  = 1'b1;
        mem_addr = ssp_q;
        if (mem_rdy) begin
          cmd.fl_ld  = 1'b1;
          cmd.fl_val = mem_rdata;
          cmd.ssp_op = SP_INC;
          state_d    = ST_POP_PC;
        end
      end
      ST_POP_PC: begin
        mem_req  = 1'b1;
        mem_addr = sup ? ssp_q : usp_q;
        if (mem_rdy) begin
          cmd.pc_ld  = 1'b1;
          cmd.pc_val = mem_rdata;
          if (sup) cmd.ssp_op = SP_INC;
          else     cmd.usp_op = SP_INC;
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign ev_pc_push = (state_q == ST_PUSH_PC) && mem_rdy;
  assign ev_fl_push = (state_q == ST_PUSH_FL) && mem_rdy;
  assign ev_vec_rd  = (state_q == ST_VEC)     && mem_rdy;
  assign ev_fl_pop  = (state_q == ST_POP_FL)  && mem_rdy;
  assign ev_pc_pop  = (state_q == ST_POP_PC)  && mem_rdy;
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter word_t       VEC_BASE = 16'h0300,
  parameter int unsigned IDX_W    = 8,
  parameter word_t       PC_RST   = 16'h0040,
  parameter word_t       FL_RST   = 16'h0005,
  parameter word_t       SSP_RST  = 16'h0200,
  parameter word_t       USP_RST  = 16'h0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        swi_go,
  input  logic        rti_go,
  input  logic [15:0] r0_val,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_rdy,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [15:0] fl_out,
  output logic [15:0] ssp_out,
  output logic [15:0] usp_out
);
  ctx_cmd_t cmd;
  logic ev_pc_push, ev_fl_push, ev_vec_rd, ev_fl_pop, ev_pc_pop;

  trap_ctx #(
    .PC_RST (PC_RST),
    .FL_RST (FL_RST),
    .SSP_RST(SSP_RST),
    .USP_RST(USP_RST)
  ) ctx_i (
    .clk  (clk),
    .rst_n(rst_n),
    .cmd  (cmd),
    .pc_q (pc_out),
    .fl_q (fl_out),
    .ssp_q(ssp_out),
    .usp_q(usp_out)
  );

  trap_fsm #(
    .VEC_BASE(VEC_BASE),
    .IDX_W   (IDX_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .swi_go    (swi_go),
    .rti_go    (rti_go),
    .r0_val    (r0_val),
    .pc_q      (pc_out),
    .fl_q      (fl_out),
    .ssp_q     (ssp_out),
    .usp_q     (usp_out),
    .mem_rdata (mem_rdata),
    .mem_rdy   (mem_rdy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done),
    .ev_pc_push(ev_pc_push),
    .ev_fl_push(ev_fl_push),
    .ev_vec_rd (ev_vec_rd),
    .ev_fl_pop (ev_fl_pop),
    .ev_pc_pop (ev_pc_pop)
  );
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
  parameter logic [15:0] VEC_BASE = 16'h0300,
  parameter int unsigned IDX_W    = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic [15:0] mem_rdata,
  input logic        mem_rdy,
  input logic        busy,
  input logic        done,
  input logic [15:0] pc_out,
  input logic [15:0] fl_out,
  input logic [15:0] ssp_out,
  input logic [15:0] usp_out,
  input logic        ev_pc_push,
  input logic        ev_fl_push,
  input logic        ev_vec_rd,
  input logic        ev_fl_pop,
  input logic        ev_pc_pop
);
  localparam logic [15:0] IDX_MASK = 16'((32'd1 << IDX_W) - 32'd1);

  p_push_below_sp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == ssp_out - 16'd1 || mem_addr == usp_out - 16'd1));

  p_pc_push_stack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pc_push |-> (mem_wdata == pc_out &&
                    mem_addr == (fl_out[15] ? ssp_out : usp_out) - 16'd1));

  p_fl_push_ssp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fl_push |-> (mem_addr == ssp_out - 16'd1 && mem_wdata == fl_out));

  p_entry_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fl_push |=> (fl_out[15] && fl_out[14] &&
                    fl_out[13:0] == $past(fl_out[13:0])));

  p_vec_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec_rd |-> ((mem_addr - VEC_BASE) <= IDX_MASK && !mem_we));

  p_vec_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec_rd |=> (pc_out == $past(mem_rdata)));

  p_iip_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fl_pop |-> (!fl_out[14] && mem_addr == ssp_out));

  p_pc_pop_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pc_pop |-> (mem_addr == (fl_out[15] ? ssp_out : usp_out)));

  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind trap_sequencer trap_sequencer_chk #(
  .VEC_BASE(VEC_BASE),
  .IDX_W   (IDX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .mem_rdy   (mem_rdy),
  .busy      (busy),
  .done      (done),
  .pc_out    (pc_out),
  .fl_out    (fl_out),
  .ssp_out   (ssp_out),
  .usp_out   (usp_out),
  .ev_pc_push(ev_pc_push),
  .ev_fl_push(ev_fl_push),
  .ev_vec_rd (ev_vec_rd),
  .ev_fl_pop (ev_fl_pop),
  .ev_pc_pop (ev_pc_pop)
);

// File: tb/trap_sequencer_tb_top.sv
module trap_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VBASE = 16'h0300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swi_go = 1'b0;
  logic        rti_go = 1'b0;
  logic [15:0] r0_val = '0;
  logic        mem_req, mem_we, mem_rdy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done;
  logic [15:0] pc_out, fl_out, ssp_out, usp_out;

  logic [15:0] mem_arr [0:1023];
  logic [7:0]  lfsr = 8'hA5;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] e_pc, e_fl, e_ssp, e_usp;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .swi_go(swi_go), .rti_go(rti_go), .r0_val(r0_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .busy(busy), .done(done),
    .pc_out(pc_out), .fl_out(fl_out), .ssp_out(ssp_out), .usp_out(usp_out)
  );

  assign mem_rdata = mem_arr[mem_addr[9:0]];
  assign mem_rdy   = lfsr[0] | lfsr[3];

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    if (mem_req && mem_rdy && mem_we) mem_arr[mem_addr[9:0]] <= mem_wdata;
  end

  function automatic logic [15:0] vec_word(int i);
    return 16'h8000 | 16'(i * 7 + 3);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (done !== 1'b1) begin
      @(negedge clk);
      guard++;
      if (guard > 2000) begin
        n_checks++; n_fail++;
        $display("FAIL R9 watchdog actual=no_done expected=done");
        finish_run();
      end
    end
  endtask

  task automatic check_ctx(input string tag);
    chk({tag, " pc"},  pc_out,  e_pc);
    chk({tag, " fl"},  fl_out,  e_fl);
    chk({tag, " ssp"}, ssp_out, e_ssp);
    chk({tag, " usp"}, usp_out, e_usp);
  endtask

  // trap entry; disturb=1 sends a return strobe while busy (R9)
  task automatic do_swi(input logic [15:0] r0, input logic also_rti, input logic disturb);
    logic [15:0] pc_slot, fl_slot, old_pc, old_fl;
    old_pc = e_pc; old_fl = e_fl;
    if (e_fl[15]) begin e_ssp = e_ssp - 16'd1; pc_slot = e_ssp; end
    else          begin e_usp = e_usp - 16'd1; pc_slot = e_usp; end
    e_ssp   = e_ssp - 16'd1;
    fl_slot = e_ssp;
    e_fl    = old_fl | 16'hC000;
    e_pc    = vec_word(int'(r0[7:0]));
    @(negedge clk);
    swi_go = 1'b1; rti_go = also_rti; r0_val = r0;
    @(negedge clk);
    swi_go = 1'b0; rti_go = disturb; r0_val = ~r0;
    chk("R9 busy after swi accept", {15'd0, busy}, 16'd1);
    @(negedge clk);
    rti_go = 1'b0;
    wait_done();
    chk("R9 busy with done", {15'd0, busy}, 16'd1);
    check_ctx("R4 R5 swi ctx");
    chk("R2 pushed pc", mem_arr[pc_slot[9:0]], old_pc);
    chk("R3 pushed fl on ssp", mem_arr[fl_slot[9:0]], old_fl);
    @(negedge clk);
    chk("R9 done single pulse", {14'd0, done, busy}, 16'd0);
  endtask

  task automatic do_rti();
    e_fl  = mem_arr[e_ssp[9:0]];
    e_ssp = e_ssp + 16'd1;
    if (e_fl[15]) begin e_pc = mem_arr[e_ssp[9:0]]; e_ssp = e_ssp + 16'd1; end
    else          begin e_pc = mem_arr[e_usp[9:0]]; e_usp = e_usp + 16'd1; end
    @(negedge clk);
    rti_go = 1'b1;
    @(negedge clk);
    rti_go = 1'b0;
    chk("R6 iip cleared before pop", {15'd0, fl_out[14]}, 16'd0);
    wait_done();
    check_ctx("R6 R7 rti ctx");
    @(negedge clk);
    chk("R9 done single pulse rti", {15'd0, done}, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL global watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem_arr[i] = 16'h0000;
    for (int i = 0; i < 256; i++) mem_arr[int'(VBASE) + i] = vec_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_pc = 16'h0040; e_fl = 16'h0005; e_ssp = 16'h0200; e_usp = 16'h0100;
    @(negedge clk);
    check_ctx("R8 reset");
    chk("R8 busy/done", {14'd0, busy, done}, 16'd0);

    // sweep of table indices: user entry, nested supervisor entry, two returns
    for (int k = 0; k < 64; k++) begin
      logic [15:0] ra, rb;
      ra = 16'((k * 4) | ((k * 16'h0B00) & 16'hFF00));
      rb = 16'(255 - k * 3) | 16'hA500;
      do_swi(ra, 1'b0, k[0]);
      do_swi(rb, 1'b0, 1'b0);
      do_rti();
      chk("R7 back in supervisor", {15'd0, fl_out[15]}, 16'd1);
      do_rti();
      chk("R7 back in user", {15'd0, fl_out[15]}, 16'd0);
      chk("R1 ssp balanced", ssp_out, 16'h0200);
      chk("R1 usp balanced", usp_out, 16'h0100);
    end

    // boundary indices and ignored high byte of R0
    do_swi(16'hFFFF, 1'b0, 1'b0);
    chk("R5 index 0xFF", pc_out, vec_word(255));
    do_rti();
    do_swi(16'h7F00, 1'b0, 1'b0);
    chk("R5 high byte ignored", pc_out, vec_word(0));
    do_rti();

    // simultaneous strobes: entry wins
    do_swi(16'h0011, 1'b1, 1'b0);
    chk("R10 swi priority usp", usp_out, 16'h00FF);
    do_rti();
    check_ctx("R10 restored");

    finish_run();
  end
endmodule